// File: doc/BRIEF.md
# Ethernet Receive Address Filter

This block sits beside the receive byte stream of an Ethernet MAC. It watches the first fourteen header bytes of each frame and decides whether the frame should be kept. It also produces a reason code, which the receive path stores with the frame so software can see why the frame was let through. The decision is made before the payload is written to memory.

There are five ways a frame can be accepted:
- its destination address equals one of four enabled address registers;
- its EtherType/length field equals one of four enabled type registers;
- a 6-bit fold of the destination address selects a set bit in a 64-bit hash mask;
- the destination is the all-ones broadcast address and broadcast reception is on;
- copy-all mode is on.

When more than one path matches, a fixed priority picks the single reported reason. The configuration inputs are sampled at the decision edge. The result then stays on the outputs until the next start of frame.

Top module: `rxf_addr_filter`

## Requirements
- R1: After reset, `dec_vld_o`, `accept_o` and `reason_o` are all zero.
- R2: A byte is consumed on a clock edge only while `byte_vld_i` is high. The byte with `sof_i` high is header byte 0. `dec_vld_o` goes high in the cycle after header byte 13 is consumed, and idle cycles between bytes only delay it.
- R3: A consumed start-of-frame byte clears `dec_vld_o`, `accept_o` and `reason_o` in the following cycle. Otherwise the decision outputs stay unchanged until the next start of frame, even if the configuration inputs change.
- R4: Header byte i (0..5) forms destination bits [8i+7:8i]. Address register k is bits [48k+47:48k] of `sa_addr_i`. A frame whose destination equals an enabled address register k is accepted with reason class 1 and index k.
- R5: The type field is {byte 12, byte 13}, with byte 12 in the upper eight bits. Type register k is bits [16k+15:16k] of `tid_val_i`. A frame whose type field equals an enabled type register k is accepted with class 2 and index k.
- R6: Hash index bit b (0..5) is the XOR of destination bits b, b+6, ..., b+42. When `hash_tbl_i[index]` is 1, the frame is accepted with class 3 and index 0.
- R7: A destination of all ones is accepted with class 4 only while `bcast_en_i` is 1.
- R8: While `copy_all_i` is 1, every frame is accepted; if no other path matches, the class is 5.
- R9: `reason_o[4:2]` holds the class and `reason_o[1:0]` holds the register index. Priority runs address registers (lowest index first), then type registers (lowest index first), then hash, then broadcast, then copy-all. With no match, `accept_o` is 0 and `reason_o` is 0.
- R10: An address or type register whose enable bit (`sa_en_i[k]`, `tid_en_i[k]`) is 0 never matches.
- R11: A byte that arrives before any start of frame, or after header byte 13 and before the next start of frame, has no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| byte_vld_i | input | 1 | Receive byte is valid this cycle |
| sof_i | input | 1 | Valid byte is the first byte of a frame |
| byte_i | input | 8 | Receive byte |
| sa_addr_i | input | 192 | Four 48-bit address match values |
| sa_en_i | input | 4 | Enable for each address register |
| tid_val_i | input | 64 | Four 16-bit type match values |
| tid_en_i | input | 4 | Enable for each type register |
| hash_tbl_i | input | 64 | Hash acceptance mask |
| bcast_en_i | input | 1 | Broadcast reception allowed |
| copy_all_i | input | 1 | Accept every frame |
| dec_vld_o | output | 1 | Decision valid |
| accept_o | output | 1 | Frame accepted |
| reason_o | output | 5 | Match class [4:2] and register index [1:0] |

## Verification
A miscounted byte position corrupts the captured address or type of every frame. That shows up at the first decision as a wrong `accept_o` or reason, or as `dec_vld_o` rising a cycle early or late.

An error in the priority chain or the index encoding shows up at the first frame where two paths overlap. The bench builds such overlaps on purpose.

An index error in the hash fold shows up within the 64-entry hash sweep. A missing hold or clear shows up within a few cycles, through the idle and trailing-byte checks after a decision.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  localparam int ADDR_W    = 48;
  localparam int TYPE_W    = 16;
  localparam int HDR_BYTES = 14;
  localparam int IDX_W     = 2;

  typedef enum logic [2:0] {
    MR_NONE  = 3'd0,
    MR_SPEC  = 3'd1,
    MR_TYPE  = 3'd2,
    MR_HASH  = 3'd3,
    MR_BCAST = 3'd4,
    MR_ALL   = 3'd5
  } match_src_e;

  typedef struct packed {
    match_src_e       src;
    logic [IDX_W-1:0] idx;
  } reason_t;
endpackage

// File: rtl/rxf_hdr_capture.sv
module rxf_hdr_capture
  import rxf_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              byte_vld_i,
  input  logic              sof_i,
  input  logic [7:0]        byte_i,
  output logic [ADDR_W-1:0] da_o,
  output logic [TYPE_W-1:0] type_o,
  output logic              start_o,
  output logic              last_o
);
  localparam int CNT_W  = $clog2(HDR_BYTES);
  localparam int DA_B   = ADDR_W / 8;
  localparam int TYPE_B = HDR_BYTES - 2;

  logic              active_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [ADDR_W-1:0] da_q;
  logic [7:0]        th_q;

  assign start_o = byte_vld_i && sof_i;
  assign last_o  = byte_vld_i && !sof_i && active_q && (cnt_q == CNT_W'(HDR_BYTES - 1));
  assign da_o    = da_q;
  // low type byte is taken live so the decision lands one cycle after byte 13
  assign type_o  = {th_q, byte_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
      da_q     <= '0;
      th_q     <= '0;
    end else if (start_o) begin
      active_q   <= 1'b1;
      cnt_q      <= CNT_W'(1);
      da_q[7:0]  <= byte_i;
    end else if (byte_vld_i && active_q) begin
      if (cnt_q < CNT_W'(DA_B)) da_q[8*int'(cnt_q) +: 8] <= byte_i;
      if (cnt_q == CNT_W'(TYPE_B)) th_q <= byte_i;
      if (cnt_q == CNT_W'(HDR_BYTES - 1)) active_q <= 1'b0;
      cnt_q <= cnt_q + 1'b1;
    end
  end

  p_cnt_range_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_q |-> (cnt_q < CNT_W'(HDR_BYTES)));
endmodule

// File: rtl/rxf_hash.sv
module rxf_hash #(
  parameter int ADDR_W    = 48,
  parameter int HASH_BITS = 6
) (
  input  logic [ADDR_W-1:0]         da_i,
  input  logic [2**HASH_BITS-1:0]   tbl_i,
  output logic [HASH_BITS-1:0]      idx_o,
  output logic                      hit_o
);
  always_comb begin
    idx_o = '0;
    for (int j = 0; j < ADDR_W; j++) idx_o[j % HASH_BITS] = idx_o[j % HASH_BITS] ^ da_i[j];
  end

  assign hit_o = tbl_i[idx_o];
endmodule

// File: rtl/rxf_match.sv
module rxf_match
  import rxf_pkg::*;
#(
  parameter int N_SA  = 4,
  parameter int N_TID = 4
) (
  input  logic [ADDR_W-1:0]       da_i,
  input  logic [TYPE_W-1:0]       type_i,
  input  logic [N_SA*ADDR_W-1:0]  sa_addr_i,
  input  logic [N_SA-1:0]         sa_en_i,
  input  logic [N_TID*TYPE_W-1:0] tid_val_i,
  input  logic [N_TID-1:0]        tid_en_i,
  input  logic                    hash_hit_i,
  input  logic                    bcast_en_i,
  input  logic                    copy_all_i,
  output reason_t                 reason_o,
  output logic                    accept_o
);
  logic [N_SA-1:0]  sa_hit;
  logic [N_TID-1:0] tid_hit;
  logic             bc_hit;

  for (genvar i = 0; i < N_SA; i++) begin : g_sa
    assign sa_hit[i] = sa_en_i[i] && (da_i == sa_addr_i[i*ADDR_W +: ADDR_W]);
  end
  for (genvar i = 0; i < N_TID; i++) begin : g_tid
    assign tid_hit[i] = tid_en_i[i] && (type_i == tid_val_i[i*TYPE_W +: TYPE_W]);
  end
  assign bc_hit = bcast_en_i && (&da_i);

  // lowest priority first; later assignments override
  always_comb begin
    reason_o = '{src: MR_NONE, idx: '0};
    if (copy_all_i) reason_o = '{src: MR_ALL, idx: '0};
    if (bc_hit)     reason_o = '{src: MR_BCAST, idx: '0};
    if (hash_hit_i) reason_o = '{src: MR_HASH, idx: '0};
    for (int i = N_TID - 1; i >= 0; i--)
      if (tid_hit[i]) reason_o = '{src: MR_TYPE, idx: IDX_W'(i)};
    for (int i = N_SA - 1; i >= 0; i--)
      if (sa_hit[i]) reason_o = '{src: MR_SPEC, idx: IDX_W'(i)};
  end

  assign accept_o = (reason_o.src != MR_NONE);
endmodule

// File: rtl/rxf_addr_filter.sv
module rxf_addr_filter
  import rxf_pkg::*;
#(
  parameter int N_SA      = 4,
  parameter int N_TID     = 4,
  parameter int HASH_BITS = 6
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    byte_vld_i,
  input  logic                    sof_i,
  input  logic [7:0]              byte_i,
  input  logic [N_SA*48-1:0]      sa_addr_i,
  input  logic [N_SA-1:0]         sa_en_i,
  input  logic [N_TID*16-1:0]     tid_val_i,
  input  logic [N_TID-1:0]        tid_en_i,
  input  logic [2**HASH_BITS-1:0] hash_tbl_i,
  input  logic                    bcast_en_i,
  input  logic                    copy_all_i,
  output logic                    dec_vld_o,
  output logic                    accept_o,
  output logic [4:0]              reason_o
);
  logic [ADDR_W-1:0]    da;
  logic [TYPE_W-1:0]    ty;
  logic                 start, last;
  logic [HASH_BITS-1:0] hash_idx;
  logic                 hash_hit;
  reason_t              reason_d, reason_q;
  logic                 acc_d, acc_q, vld_q;

  rxf_hdr_capture u_cap (
    .clk_i, .rst_ni, .byte_vld_i, .sof_i, .byte_i,
    .da_o(da), .type_o(ty), .start_o(start), .last_o(last)
  );

  rxf_hash #(.ADDR_W(ADDR_W), .HASH_BITS(HASH_BITS)) u_hash (
    .da_i(da), .tbl_i(hash_tbl_i), .idx_o(hash_idx), .hit_o(hash_hit)
  );

  rxf_match #(.N_SA(N_SA), .N_TID(N_TID)) u_match (
    .da_i(da), .type_i(ty), .sa_addr_i, .sa_en_i, .tid_val_i, .tid_en_i,
    .hash_hit_i(hash_hit), .bcast_en_i, .copy_all_i,
    .reason_o(reason_d), .accept_o(acc_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q    <= 1'b0;
      acc_q    <= 1'b0;
      reason_q <= '{src: MR_NONE, idx: '0};
    end else if (start) begin
      vld_q    <= 1'b0;
      acc_q    <= 1'b0;
      reason_q <= '{src: MR_NONE, idx: '0};
    end else if (last) begin
      vld_q    <= 1'b1;
      acc_q    <= acc_d;
      reason_q <= reason_d;
    end
  end

  assign dec_vld_o = vld_q;
  assign accept_o  = acc_q;
  assign reason_o  = reason_q;

  p_timing_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last |=> dec_vld_o);
  p_sof_clears_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_vld_i && sof_i) |=> (!dec_vld_o && !accept_o));
  p_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_vld_o && !(byte_vld_i && sof_i)) |=>
      (dec_vld_o && $stable(accept_o) && $stable(reason_o)));
  p_copy_all_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (last && copy_all_i) |=> accept_o);
  p_bcast_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (last && bcast_en_i && (&da)) |=> accept_o);
endmodule

// File: tb/sim_rxf_addr_filter.sv
`timescale 1ns/1ps
module sim_rxf_addr_filter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        vld = 1'b0, sof = 1'b0;
  logic [7:0]  bt = '0;
  logic [47:0] sa [4];
  logic [15:0] tid [4];
  logic [3:0]  sa_en = '0, tid_en = '0;
  logic [63:0] htbl = '0;
  logic        bc_en = 1'b0, call = 1'b0;
  logic        dvld, acc;
  logic [4:0]  rsn;
  int checks = 0, fails = 0;
  logic [31:0] seed = 32'h1357_2468;

  always #2.5 clk = ~clk;

  rxf_addr_filter u0 (
    .clk_i(clk), .rst_ni(rst_n), .byte_vld_i(vld), .sof_i(sof), .byte_i(bt),
    .sa_addr_i({sa[3], sa[2], sa[1], sa[0]}), .sa_en_i(sa_en),
    .tid_val_i({tid[3], tid[2], tid[1], tid[0]}), .tid_en_i(tid_en),
    .hash_tbl_i(htbl), .bcast_en_i(bc_en), .copy_all_i(call),
    .dec_vld_o(dvld), .accept_o(acc), .reason_o(rsn)
  );

  task automatic chk(input string req, input logic [6:0] act, input logic [6:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  function automatic logic [5:0] hidx(input logic [47:0] d);
    logic [5:0] r = '0;
    for (int b = 0; b < 6; b++)
      for (int g = 0; g < 8; g++) r[b] = r[b] ^ d[6*g + b];
    return r;
  endfunction

  // {accept, class[2:0], idx[1:0]}
  function automatic logic [5:0] model(input logic [47:0] d, input logic [15:0] t);
    for (int k = 0; k < 4; k++) if (sa_en[k] && d == sa[k]) return {1'b1, 3'd1, 2'(k)};
    for (int k = 0; k < 4; k++) if (tid_en[k] && t == tid[k]) return {1'b1, 3'd2, 2'(k)};
    if (htbl[hidx(d)]) return {1'b1, 3'd3, 2'd0};
    if (bc_en && d == 48'hFFFF_FFFF_FFFF) return {1'b1, 3'd4, 2'd0};
    if (call) return {1'b1, 3'd5, 2'd0};
    return 6'd0;
  endfunction

  function automatic logic [31:0] rnd();
    seed = seed * 32'd1664525 + 32'd1013904223;
    return seed;
  endfunction

  task automatic frame(input logic [47:0] d, input logic [15:0] t, input int gap);
    for (int i = 0; i < 14; i++) begin
      @(negedge clk);
      if (i == 13) chk("R2/R3 not valid before byte 13", {dvld, 6'd0}, 7'd0);
      vld = 1'b1;
      sof = (i == 0);
      bt  = (i < 6) ? d[8*i +: 8] : (i == 12) ? t[15:8] : (i == 13) ? t[7:0] : 8'(i * 17);
      for (int g = 0; g < gap; g++) begin
        @(negedge clk);
        vld = 1'b0; sof = 1'b0;
      end
    end
    @(negedge clk);
    vld = 1'b0; sof = 1'b0;
  endtask

  task automatic run(input string req, input logic [47:0] d, input logic [15:0] t, input int gap);
    logic [5:0] e;
    e = model(d, t);
    frame(d, t, gap);
    chk(req, {dvld, acc, rsn}, {1'b1, e});
  endtask

  initial begin
    #(5.0 * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [6:0] held;
    logic [47:0] d;
    logic [15:0] t;
    for (int k = 0; k < 4; k++) begin
      sa[k]  = 48'h0200_0000_0000 + 48'(k * 48'h0101_0203_0405) + 48'h11;
      tid[k] = 16'h8800 + 16'(k * 3);
    end
    #12 rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset state", {dvld, acc, rsn}, 7'd0);

    // R11: stray bytes before any start of frame
    for (int i = 0; i < 20; i++) begin
      @(negedge clk); vld = 1'b1; bt = 8'(i);
    end
    @(negedge clk); vld = 1'b0;
    chk("R11 bytes before sof ignored", {dvld, acc, rsn}, 7'd0);

    // R4 / R10: address registers
    sa_en = 4'hF;
    for (int k = 0; k < 4; k++) run("R4 address match", sa[k], 16'h0800, 0);
    for (int k = 0; k < 4; k++) begin
      sa_en = ~(4'b1 << k);
      run("R10 disabled address reg", sa[k], 16'h0800, 0);
    end
    sa_en = 4'h0;

    // R5 / R10: type registers
    tid_en = 4'hF;
    for (int k = 0; k < 4; k++) run("R5 type match", 48'h0A0B_0C0D_0E0F, tid[k], 0);
    for (int k = 0; k < 4; k++) begin
      tid_en = ~(4'b1 << k);
      run("R10 disabled type reg", 48'h0A0B_0C0D_0E0F, tid[k], 0);
    end
    tid_en = 4'h0;

    // R6: hash sweep over every index
    for (int i = 0; i < 64; i++) begin
      d = {42'h0, 6'(i)} ^ {6'(i * 5), 36'h0, 6'(i * 5)};
      htbl = 64'b1 << hidx(d);
      run("R6 hash hit", d, 16'h0800, 0);
      htbl = ~(64'b1 << hidx(d));
      run("R6 hash miss", d, 16'h0800, 0);
    end
    htbl = '0;

    // R7
    run("R7 broadcast disabled", 48'hFFFF_FFFF_FFFF, 16'h0806, 0);
    bc_en = 1'b1;
    run("R7 broadcast enabled", 48'hFFFF_FFFF_FFFF, 16'h0806, 0);

    // R8
    call = 1'b1;
    run("R8 copy-all", 48'h1234_5678_9ABC, 16'h0001, 0);

    // R9 priority with overlaps
    sa[2] = 48'hFFFF_FFFF_FFFF; sa[3] = 48'hFFFF_FFFF_FFFF; tid[1] = 16'h86DD; tid[3] = 16'h86DD;
    htbl = 64'b1 << hidx(48'hFFFF_FFFF_FFFF);
    sa_en = 4'hC; tid_en = 4'hA;
    run("R9 address over all", 48'hFFFF_FFFF_FFFF, 16'h86DD, 0);
    sa_en = 4'h0;
    run("R9 type over hash", 48'hFFFF_FFFF_FFFF, 16'h86DD, 0);
    tid_en = 4'h0;
    run("R9 hash over broadcast", 48'hFFFF_FFFF_FFFF, 16'h86DD, 0);
    htbl = '0;
    run("R9 broadcast over copy-all", 48'hFFFF_FFFF_FFFF, 16'h86DD, 0);
    call = 1'b0; bc_en = 1'b0;
    run("R9 no match", 48'hFFFF_FFFF_FFFF, 16'h86DD, 0);

    // R2: idle gaps between bytes
    sa_en = 4'h1;
    run("R2 frame with gaps", sa[0], 16'h0800, 2);

    // R3 / R11: hold against config changes and trailing bytes
    held = {dvld, acc, rsn};
    call = 1'b1; sa_en = 4'h0;
    repeat (3) @(negedge clk);
    chk("R3 hold after config change", {dvld, acc, rsn}, held);
    for (int i = 0; i < 16; i++) begin
      @(negedge clk); vld = 1'b1; bt = 8'hFF;
    end
    @(negedge clk); vld = 1'b0;
    chk("R11 trailing bytes ignored", {dvld, acc, rsn}, held);
    @(negedge clk); vld = 1'b1; sof = 1'b1; bt = 8'h00;
    @(negedge clk); vld = 1'b0; sof = 1'b0;
    chk("R3 sof clears decision", {dvld, acc, rsn}, 7'd0);
    call = 1'b0;

    // mixed sweep
    for (int n = 0; n < 200; n++) begin
      logic [31:0] r;
      r = rnd();
      sa_en = r[3:0]; tid_en = r[7:4]; bc_en = r[8]; call = (r[11:9] == 0);
      htbl = {rnd(), rnd()} & {rnd(), rnd()};
      d = {rnd(), rnd()}[47:0];
      t = rnd()[15:0];
      case (r[14:12])
        3'd0, 3'd1: d = sa[r[17:16]];
        3'd2:       t = tid[r[19:18]];
        3'd3:       d = 48'hFFFF_FFFF_FFFF;
        default: ;
      endcase
      run("R9 mixed sweep", d, t, int'(r[21:20] == 0));
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule